// File: doc/BRIEF.md
# Multi-Kernel Workgroup Dispatch Scheduler

This block sits between a launch source and an array of compute units. Launching a kernel fills a context slot with its workgroup count and a notify option, and puts the slot ID on a pending queue. Each scheduler tick walks that queue and issues workgroups from the head kernel over a valid/accept handshake. When the array refuses a workgroup, the kernel goes to the back of the queue. Kernels behind it, which may need fewer resources, can then issue in the same tick. The tick stops once every kernel still queued has been refused in it.

Completion reports come back tagged with a kernel ID. When a kernel's last workgroup completes, the block frees its slot and decrements an outstanding-kernel counter. It raises a notify pulse if the launch asked for one, and records the ID in a done queue. At the end of a tick, a non-empty done queue produces a one-cycle host wake pulse, and the done IDs are then streamed out one per cycle.

Top module: `kd_wg_dispatch`

## Requirements
- R1: While the head kernel has workgroups left, each cycle in which `wg_valid` is high presents that kernel on `wg_kernel` and its next workgroup number on `wg_index`, counting from 0 upwards. An accepted workgroup is never offered again.
- R2: A refused workgroup (`wg_valid` high, `wg_accept` low) moves its kernel to the tail of the pending queue. The next queued kernel is then offered, so a blocked kernel does not hold back kernels behind it.
- R3: The refusal count is cleared when a tick starts. The tick ends once the queue occupancy is no longer greater than that count, so a kernel that is refused is offered at most once per tick unless other work moves it.
- R4: Each valid completion report adds one to that kernel's completed count. When the count reaches the launch's workgroup count, the kernel is done and its slot can be launched again.
- R5: A done kernel's ID enters the done queue. At the end of a tick with that queue non-empty, `host_wake` is high for one cycle. The IDs then appear on `done_id` with `done_valid`, one per cycle, in completion order.
- R6: When a kernel completes, `notify_valid` pulses with `notify_id` equal to its ID, but only if `launch_notify` was 1 at its launch.
- R7: `outstanding` rises by 1 for each accepted launch and falls by 1 for each kernel completion.
- R8: An accepted launch or a valid completion report requests a scheduler tick. The request is kept until the controller is idle and starts the tick.
- R9: A completion report for a slot that is not active sets `err_flag`, which stays set until reset. The report changes no other output.
- R10: A launch into a slot that is already active, or with a workgroup count of 0, is ignored.
- R11: After reset, `wg_valid`, `host_wake`, `done_valid`, `notify_valid` and `err_flag` are 0, and `outstanding` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| launch_valid | input | 1 | Launch request |
| launch_id | input | ID_W | Context slot to launch |
| launch_wgs | input | CNT_W | Workgroup count of the kernel |
| launch_notify | input | 1 | Pulse notify on completion |
| wg_valid | output | 1 | Workgroup offered to the array |
| wg_kernel | output | ID_W | Kernel of the offered workgroup |
| wg_index | output | CNT_W | Workgroup number within the kernel |
| wg_accept | input | 1 | Array takes the offered workgroup (same cycle) |
| cmpl_valid | input | 1 | Workgroup completion report |
| cmpl_id | input | ID_W | Kernel of the completed workgroup |
| notify_valid | output | 1 | Kernel completion notify pulse |
| notify_id | output | ID_W | Kernel being notified |
| outstanding | output | OUT_W | Kernels launched and not yet complete |
| host_wake | output | 1 | One-cycle host wake pulse |
| done_valid | output | 1 | Done ID valid |
| done_id | output | ID_W | Completed kernel ID |
| err_flag | output | 1 | Sticky stray-completion error |

## Verification
Some rules are checked by assertions on every cycle. An offered workgroup always has remaining work behind it and a non-empty queue. A refusal advances the failure count and returns the controller to its scan state. The failure count never exceeds the queue occupancy, and neither queue overflows. A wake pulse is followed by the done stream. The error flag and the outstanding count follow their update rules. Other behaviour shows only in the bench's scenarios: the order in which workgroups from several kernels reach the array, a small kernel passing a blocked one, one refusal per tick, slot reuse, and the absence of any effect from ignored launches and stray reports.

// File: rtl/kd_pkg.sv
package kd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCAN,
    ST_ISSUE,
    ST_END,
    ST_DRAIN
  } kd_state_e;

  // A tick keeps walking while more kernels are queued than have been refused.
  function automatic logic tick_has_work(input int occupancy, input int refusals);
    return occupancy > refusals;
  endfunction

endpackage

// File: rtl/kd_idq.sv
module kd_idq #(
  parameter int DEPTH = 4,
  parameter int W     = 2,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_a,
  input  logic [W-1:0]  data_a,
  input  logic          push_b,
  input  logic [W-1:0]  data_b,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count
);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;

  function automatic logic [PW-1:0] advance(input logic [PW-1:0] p, input int k);
    return PW'((int'(p) + k) % DEPTH);
  endfunction

  assign head = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (push_a) mem[wr_ptr] <= data_a;
      if (push_b) mem[push_a ? advance(wr_ptr, 1) : wr_ptr] <= data_b;
      wr_ptr <= advance(wr_ptr, int'(push_a) + int'(push_b));
      if (pop) rd_ptr <= advance(rd_ptr, 1);
      count <= CW'(int'(count) + int'(push_a) + int'(push_b) - int'(pop));
    end
  end

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(count) + int'(push_a) + int'(push_b) - int'(pop)) <= DEPTH);

  assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> count != '0);

endmodule

// File: rtl/kd_ctx_table.sv
module kd_ctx_table #(
  parameter int N     = 4,
  parameter int CNT_W = 8,
  localparam int ID_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch_valid,
  input  logic [ID_W-1:0]  launch_id,
  input  logic [CNT_W-1:0] launch_wgs,
  input  logic             launch_notify,
  input  logic             take,
  input  logic [ID_W-1:0]  head_id,
  input  logic             cmpl_valid,
  input  logic [ID_W-1:0]  cmpl_id,
  output logic             launch_ok,
  output logic             cmpl_ok,
  output logic             kernel_done,
  output logic             done_notify,
  output logic [CNT_W-1:0] head_rem,
  output logic [CNT_W-1:0] head_idx,
  output logic             err_flag
);

  logic [N-1:0]     active;
  logic [N-1:0]     notify_en;
  logic [CNT_W-1:0] total     [N];
  logic [CNT_W-1:0] remaining [N];
  logic [CNT_W-1:0] completed [N];

  // True when one more completion finishes the kernel.
  function automatic logic last_completion(input logic [CNT_W-1:0] done_cnt,
                                           input logic [CNT_W-1:0] wgs);
    return ({1'b0, done_cnt} + 1'b1) == {1'b0, wgs};
  endfunction

  assign launch_ok   = launch_valid && !active[launch_id] && (launch_wgs != '0);
  assign cmpl_ok     = cmpl_valid && active[cmpl_id];
  assign kernel_done = cmpl_ok && last_completion(completed[cmpl_id], total[cmpl_id]);
  assign done_notify = kernel_done && notify_en[cmpl_id];
  assign head_rem    = remaining[head_id];
  assign head_idx    = total[head_id] - remaining[head_id];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= '0;
      notify_en <= '0;
      err_flag  <= 1'b0;
      for (int k = 0; k < N; k++) begin
        total[k]     <= '0;
        remaining[k] <= '0;
        completed[k] <= '0;
      end
    end else begin
      if (cmpl_valid && !active[cmpl_id]) err_flag <= 1'b1;
      for (int k = 0; k < N; k++) begin
        if (launch_ok && launch_id == ID_W'(k)) begin
          active[k]    <= 1'b1;
          notify_en[k] <= launch_notify;
          total[k]     <= launch_wgs;
          remaining[k] <= launch_wgs;
          completed[k] <= '0;
        end else begin
          if (take && head_id == ID_W'(k)) remaining[k] <= remaining[k] - 1'b1;
          if (cmpl_ok && cmpl_id == ID_W'(k)) begin
            completed[k] <= completed[k] + 1'b1;
            if (kernel_done) active[k] <= 1'b0;
          end
        end
      end
    end
  end

  assert_take_has_work_R1: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (active[head_id] && remaining[head_id] != '0));

  assert_cmpl_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_ok |-> completed[cmpl_id] < total[cmpl_id]);

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  assert_stray_sets_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_valid && !cmpl_ok) |=> err_flag);

endmodule

// File: rtl/kd_sched_fsm.sv
module kd_sched_fsm
  import kd_pkg::*;
#(
  parameter int QCW   = 3,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_req,
  input  logic [QCW-1:0]   q_count,
  input  logic [CNT_W-1:0] head_rem,
  input  logic             wg_accept,
  input  logic             done_nonempty,
  output logic             wg_valid,
  output logic             q_pop,
  output logic             q_rotate,
  output logic             host_wake,
  output logic             done_pop
);

  kd_state_e      state;
  logic [QCW-1:0] fail_cnt;
  logic           tick_pending;

  assign wg_valid  = (state == ST_ISSUE);
  assign q_rotate  = wg_valid && !wg_accept;
  assign q_pop     = wg_valid && (!wg_accept || head_rem == CNT_W'(1));
  assign host_wake = (state == ST_END) && done_nonempty;
  assign done_pop  = (state == ST_DRAIN) && done_nonempty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      fail_cnt     <= '0;
      tick_pending <= 1'b0;
    end else begin
      tick_pending <= tick_req || (tick_pending && state != ST_IDLE);
      unique case (state)
        ST_IDLE: if (tick_pending) begin
          state    <= ST_SCAN;
          fail_cnt <= '0;
        end
        ST_SCAN: state <= tick_has_work(int'(q_count), int'(fail_cnt)) ? ST_ISSUE : ST_END;
        ST_ISSUE: begin
          if (!wg_accept) begin
            fail_cnt <= fail_cnt + 1'b1;
            state    <= ST_SCAN;
          end else if (head_rem == CNT_W'(1)) begin
            state <= ST_SCAN;
          end
        end
        ST_END:   state <= done_nonempty ? ST_DRAIN : ST_IDLE;
        ST_DRAIN: if (!done_nonempty) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assert_issue_nonempty_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wg_valid |-> q_count != '0);

  assert_refusal_rotates_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wg_valid && !wg_accept) |=> (state == ST_SCAN && fail_cnt == $past(fail_cnt) + 1'b1));

  assert_fail_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fail_cnt <= q_count);

  assert_wake_then_drain_R5: assert property (@(posedge clk) disable iff (!rst_n)
    host_wake |=> (state == ST_DRAIN && done_nonempty));

  assert_tick_request_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tick_req |=> tick_pending);

endmodule

// File: rtl/kd_wg_dispatch.sv
module kd_wg_dispatch #(
  parameter int  NUM_KERNELS = 4,
  parameter int  CNT_W       = 8,
  parameter int  DONE_DEPTH  = 2 * NUM_KERNELS,
  localparam int ID_W        = (NUM_KERNELS > 1) ? $clog2(NUM_KERNELS) : 1,
  localparam int OUT_W       = $clog2(NUM_KERNELS + 1),
  localparam int QCW         = $clog2(NUM_KERNELS + 1),
  localparam int DCW         = $clog2(DONE_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch_valid,
  input  logic [ID_W-1:0]  launch_id,
  input  logic [CNT_W-1:0] launch_wgs,
  input  logic             launch_notify,
  output logic             wg_valid,
  output logic [ID_W-1:0]  wg_kernel,
  output logic [CNT_W-1:0] wg_index,
  input  logic             wg_accept,
  input  logic             cmpl_valid,
  input  logic [ID_W-1:0]  cmpl_id,
  output logic             notify_valid,
  output logic [ID_W-1:0]  notify_id,
  output logic [OUT_W-1:0] outstanding,
  output logic             host_wake,
  output logic             done_valid,
  output logic [ID_W-1:0]  done_id,
  output logic             err_flag
);

  logic             launch_ok, cmpl_ok, kernel_done, done_notify;
  logic             q_pop, q_rotate, done_pop;
  logic [ID_W-1:0]  q_head;
  logic [QCW-1:0]   q_count;
  logic [DCW-1:0]   done_count;
  logic [CNT_W-1:0] head_rem, head_idx;
  logic             take;

  assign take      = wg_valid && wg_accept;
  assign wg_kernel = q_head;
  assign wg_index  = head_idx;
  assign done_valid = done_pop;

  kd_idq #(.DEPTH(NUM_KERNELS), .W(ID_W)) u_pending (
    .clk    (clk),
    .rst_n  (rst_n),
    .push_a (q_rotate),
    .data_a (q_head),
    .push_b (launch_ok),
    .data_b (launch_id),
    .pop    (q_pop),
    .head   (q_head),
    .count  (q_count)
  );

  kd_idq #(.DEPTH(DONE_DEPTH), .W(ID_W)) u_done (
    .clk    (clk),
    .rst_n  (rst_n),
    .push_a (kernel_done),
    .data_a (cmpl_id),
    .push_b (1'b0),
    .data_b ('0),
    .pop    (done_pop),
    .head   (done_id),
    .count  (done_count)
  );

  kd_ctx_table #(.N(NUM_KERNELS), .CNT_W(CNT_W)) u_ctx (
    .clk           (clk),
    .rst_n         (rst_n),
    .launch_valid  (launch_valid),
    .launch_id     (launch_id),
    .launch_wgs    (launch_wgs),
    .launch_notify (launch_notify),
    .take          (take),
    .head_id       (q_head),
    .cmpl_valid    (cmpl_valid),
    .cmpl_id       (cmpl_id),
    .launch_ok     (launch_ok),
    .cmpl_ok       (cmpl_ok),
    .kernel_done   (kernel_done),
    .done_notify   (done_notify),
    .head_rem      (head_rem),
    .head_idx      (head_idx),
    .err_flag      (err_flag)
  );

  kd_sched_fsm #(.QCW(QCW), .CNT_W(CNT_W)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick_req      (launch_ok || cmpl_ok),
    .q_count       (q_count),
    .head_rem      (head_rem),
    .wg_accept     (wg_accept),
    .done_nonempty (done_count != '0),
    .wg_valid      (wg_valid),
    .q_pop         (q_pop),
    .q_rotate      (q_rotate),
    .host_wake     (host_wake),
    .done_pop      (done_pop)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      notify_valid <= 1'b0;
      notify_id    <= '0;
      outstanding  <= '0;
    end else begin
      notify_valid <= done_notify;
      if (done_notify) notify_id <= cmpl_id;
      outstanding  <= OUT_W'(int'(outstanding) + int'(launch_ok) - int'(kernel_done));
    end
  end

  assert_outstanding_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_ok && !kernel_done) |=> outstanding == $past(outstanding) + 1'b1);

  assert_outstanding_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (kernel_done && !launch_ok) |=> outstanding == $past(outstanding) - 1'b1);

  assert_notify_on_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    notify_valid |-> $past(kernel_done));

endmodule

// File: tb/test_kd_wg_dispatch.sv
module test_kd_wg_dispatch;

  localparam int N     = 4;
  localparam int CNT_W = 8;
  localparam int ID_W  = 2;
  localparam int OUT_W = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             launch_valid = 1'b0;
  logic [ID_W-1:0]  launch_id = '0;
  logic [CNT_W-1:0] launch_wgs = '0;
  logic             launch_notify = 1'b0;
  logic             wg_valid;
  logic [ID_W-1:0]  wg_kernel;
  logic [CNT_W-1:0] wg_index;
  logic             wg_accept;
  logic             cmpl_valid = 1'b0;
  logic [ID_W-1:0]  cmpl_id = '0;
  logic             notify_valid;
  logic [ID_W-1:0]  notify_id;
  logic [OUT_W-1:0] outstanding;
  logic             host_wake;
  logic             done_valid;
  logic [ID_W-1:0]  done_id;
  logic             err_flag;

  logic [N-1:0] accept_mask = '1;
  assign wg_accept = accept_mask[wg_kernel];

  int n_checks = 0;
  int n_fail   = 0;
  int refusals = 0;
  int wakes    = 0;
  bit finished = 1'b0;
  int exp_issue[$];
  int exp_done[$];
  int exp_notify[$];

  always #5 clk = ~clk;

  kd_wg_dispatch #(.NUM_KERNELS(N), .CNT_W(CNT_W)) i_kd_wg_dispatch (
    .clk, .rst_n, .launch_valid, .launch_id, .launch_wgs, .launch_notify,
    .wg_valid, .wg_kernel, .wg_index, .wg_accept, .cmpl_valid, .cmpl_id,
    .notify_valid, .notify_id, .outstanding, .host_wake, .done_valid,
    .done_id, .err_flag
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_launch(input int id, input int wgs, input bit notify);
    @(posedge clk); #1;
    launch_valid  = 1'b1;
    launch_id     = ID_W'(id);
    launch_wgs    = CNT_W'(wgs);
    launch_notify = notify;
    @(posedge clk); #1;
    launch_valid = 1'b0;
  endtask

  task automatic do_cmpl(input int id);
    @(posedge clk); #1;
    cmpl_valid = 1'b1;
    cmpl_id    = ID_W'(id);
    @(posedge clk); #1;
    cmpl_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Scoreboard monitor: compares issued workgroups, done IDs and notifies.
  always @(negedge clk) begin
    if (rst_n) begin
      if (wg_valid && wg_accept) begin
        if (exp_issue.size() == 0)
          check(1'b0, "R1 unexpected issue", int'(wg_kernel) * 256 + int'(wg_index), -1);
        else begin
          int e;
          e = exp_issue.pop_front();
          check(e == int'(wg_kernel) * 256 + int'(wg_index), "R1/R2 issue order",
                int'(wg_kernel) * 256 + int'(wg_index), e);
        end
      end
      if (wg_valid && !wg_accept) refusals++;
      if (host_wake) wakes++;
      if (done_valid) begin
        if (exp_done.size() == 0) check(1'b0, "R5 unexpected done", int'(done_id), -1);
        else begin
          int e;
          e = exp_done.pop_front();
          check(e == int'(done_id), "R5 done id", int'(done_id), e);
        end
      end
      if (notify_valid) begin
        if (exp_notify.size() == 0) check(1'b0, "R6 unexpected notify", int'(notify_id), -1);
        else begin
          int e;
          e = exp_notify.pop_front();
          check(e == int'(notify_id), "R6 notify id", int'(notify_id), e);
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog R8 actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R11: reset state
    check(!wg_valid && !host_wake && !done_valid && !notify_valid, "R11 outputs idle",
          int'(wg_valid) + int'(host_wake) + int'(done_valid) + int'(notify_valid), 0);
    check(outstanding == 0, "R11 outstanding", int'(outstanding), 0);
    check(!err_flag, "R11 err_flag", int'(err_flag), 0);

    // Single kernel, three workgroups, notify enabled.
    exp_issue.push_back(0 * 256 + 0);
    exp_issue.push_back(0 * 256 + 1);
    exp_issue.push_back(0 * 256 + 2);
    do_launch(0, 3, 1'b1);
    idle(12);
    check(exp_issue.size() == 0, "R1 all workgroups issued", exp_issue.size(), 0);
    check(outstanding == 1, "R7 after launch", int'(outstanding), 1);
    exp_done.push_back(0);
    exp_notify.push_back(0);
    do_cmpl(0);
    do_cmpl(0);
    idle(4);
    check(exp_done.size() == 1, "R4 not done before last completion", exp_done.size(), 1);
    do_cmpl(0);
    idle(12);
    check(exp_done.size() == 0 && exp_notify.size() == 0, "R5/R6 done and notify seen",
          exp_done.size() + exp_notify.size(), 0);
    check(wakes >= 1, "R5 host wake pulse", wakes, 1);
    check(outstanding == 0, "R7 after completion", int'(outstanding), 0);

    // Stray completion for an inactive slot.
    do_cmpl(3);
    idle(12);
    check(err_flag, "R9 err_flag set", int'(err_flag), 1);
    check(outstanding == 0, "R9 outstanding unchanged", int'(outstanding), 0);

    // Blocked kernel 1 is passed by kernel 2.
    accept_mask = 4'b1101;
    refusals = 0;
    exp_issue.push_back(2 * 256 + 0);
    exp_issue.push_back(2 * 256 + 1);
    do_launch(1, 2, 1'b0);
    do_launch(2, 2, 1'b1);
    idle(30);
    check(exp_issue.size() == 0, "R2 later kernel passes blocked one", exp_issue.size(), 0);
    check(refusals == 2, "R3 one refusal per tick", refusals, 2);
    check(outstanding == 2, "R7 two kernels outstanding", int'(outstanding), 2);

    // Ignored launches: active slot, zero count.
    do_launch(2, 5, 1'b1);
    do_launch(3, 0, 1'b0);
    idle(12);
    check(outstanding == 2, "R10 ignored launches", int'(outstanding), 2);

    // Unblock kernel 1; completions of kernel 2 request ticks.
    accept_mask = 4'b1111;
    exp_issue.push_back(1 * 256 + 0);
    exp_issue.push_back(1 * 256 + 1);
    exp_done.push_back(2);
    exp_notify.push_back(2);
    do_cmpl(2);
    do_cmpl(2);
    idle(20);
    check(exp_issue.size() == 0, "R8 completion triggers tick", exp_issue.size(), 0);
    check(outstanding == 1, "R7 one left", int'(outstanding), 1);
    exp_done.push_back(1);
    do_cmpl(1);
    do_cmpl(1);
    idle(20);
    check(exp_done.size() == 0 && exp_notify.size() == 0, "R6 no notify for kernel 1",
          exp_done.size() + exp_notify.size(), 0);
    check(outstanding == 0, "R7 all complete", int'(outstanding), 0);

    // Slot reuse after completion.
    exp_issue.push_back(0 * 256 + 0);
    exp_done.push_back(0);
    do_launch(0, 1, 1'b0);
    idle(10);
    do_cmpl(0);
    idle(15);
    check(exp_issue.size() == 0 && exp_done.size() == 0, "R4 slot reused",
          exp_issue.size() + exp_done.size(), 0);
    check(err_flag, "R9 err_flag still set", int'(err_flag), 1);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule